// File: doc/BRIEF.md
# Receive Sample Saturation Limiter with Sticky Clip Flag

This block sits at the end of a receive datapath. Upstream logic produces samples with two bits of headroom above the 16-bit word that leaves the chip. The limiter folds each sample into the range allowed by the selected word format and hands out a registered 16-bit result. Two formats are supported. In the wide format the word has one sign bit and fifteen magnitude bits. In the narrow format the word has two sign bits and fourteen magnitude bits.

Whenever a sample has to be limited, a clip flag is raised on an output pin. The flag holds its value until control software writes a zero to the clip bit of the configuration register. The register decoder outside this block turns that write into a strobe plus the written bit value. The same flag is also offered as a status bit, so that a register read can observe it.

Top module: `rxsat_guard`

## Requirements
- R1: While and after synchronous reset, `smp_out` is 0x0000, `out_vld` is 0 and both `clip_o` and `clip_sts` are 0.
- R2: With `fmt_sel` = 1 (one sign bit), an accepted sample greater than +32767 yields 0x7FFF and one less than -32768 yields 0x8000.
- R3: With `fmt_sel` = 0 (two sign bits), an accepted sample greater than +16383 yields 0x3FFF and one less than -16384 yields 0xC000.
- R4: A sample within the limits of the selected format leaves as its low 16 bits, unchanged. `smp_out` and `out_vld` update one clock after the sample is accepted. While `in_vld` is low, `smp_out` holds its value.
- R5: A limited sample sets `clip_o` in the same cycle that the limited word appears on `smp_out`.
- R6: Once set, `clip_o` stays high through any number of in-range samples and idle cycles until a clear is written.
- R7: A register write with `clr_wr` = 1 and `clr_bit` = 0 drops `clip_o` one clock later. A write with `clr_bit` = 1 has no effect on the flag.
- R8: If a clear write and a limited sample arrive in the same cycle, the flag stays set.
- R9: `clip_sts` always reads the same value as `clip_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample on `smp_in` is valid this cycle |
| smp_in | input | 18 | Signed two's-complement sample with headroom |
| fmt_sel | input | 1 | 1 = one sign bit, 0 = two sign bits |
| clr_wr | input | 1 | Decoded write strobe for the clip bit |
| clr_bit | input | 1 | Value written to the clip bit (0 clears) |
| smp_out | output | 16 | Registered limited sample |
| out_vld | output | 1 | `smp_out` was updated on the last edge |
| clip_o | output | 1 | Sticky clip indication pin |
| clip_sts | output | 1 | Clip flag as seen by a register read |

## Verification
Every result is due exactly one rising edge after its cause. For an accepted sample this covers the limited word, the valid bit and the flag. For a clear write it is the fall of the flag. The bench drives inputs on the falling edge. It lets one rising edge pass and samples the outputs at the next falling edge, so each check sees the state created by that edge alone. For the sticky behaviour, the bench follows a clipped sample with several in-range samples and idle cycles before it writes the clear. This shows that the flag does not decay on its own.

// File: rtl/rxsat_pkg.sv
package rxsat_pkg;

  // Word format select; the encoding matches the fmt_sel pin.
  typedef enum logic {
    FMT_TWO_SIGN = 1'b0,
    FMT_ONE_SIGN = 1'b1
  } rx_fmt_e;

  // Largest positive value representable with the given count of magnitude bits.
  function automatic int pos_limit(input int mag_bits);
    return (1 << mag_bits) - 1;
  endfunction

  // Most negative value for the same magnitude width.
  function automatic int neg_limit(input int mag_bits);
    return -(1 << mag_bits);
  endfunction

endpackage

// File: rtl/rxsat_limiter.sv
module rxsat_limiter
  import rxsat_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  smp_in,
  input  rx_fmt_e          fmt,
  output logic [OUT_W-1:0] smp_out,
  output logic             out_vld,
  output logic             clip_evt
);

  // Magnitude widths for the two formats.
  localparam int MAG_ONE = OUT_W - 1;
  localparam int MAG_TWO = OUT_W - 2;
  localparam logic [IN_W-1:0] HI_ONE = IN_W'(pos_limit(MAG_ONE));
  localparam logic [IN_W-1:0] LO_ONE = IN_W'(neg_limit(MAG_ONE));
  localparam logic [IN_W-1:0] HI_TWO = IN_W'(pos_limit(MAG_TWO));
  localparam logic [IN_W-1:0] LO_TWO = IN_W'(neg_limit(MAG_TWO));

  logic signed [IN_W-1:0] s_in;
  logic signed [IN_W-1:0] hi_lim;
  logic signed [IN_W-1:0] lo_lim;
  logic                   over;
  logic                   under;
  logic [OUT_W-1:0]       sat_w;

  assign s_in = $signed(smp_in);

  // Pick the limit pair for the active format.
  always_comb begin
    if (fmt == FMT_ONE_SIGN) begin
      hi_lim = $signed(HI_ONE);
      lo_lim = $signed(LO_ONE);
    end else begin
      hi_lim = $signed(HI_TWO);
      lo_lim = $signed(LO_TWO);
    end
  end

  assign over  = s_in > hi_lim;
  assign under = s_in < lo_lim;

  always_comb begin
    if (over)       sat_w = hi_lim[OUT_W-1:0];
    else if (under) sat_w = lo_lim[OUT_W-1:0];
    else            sat_w = smp_in[OUT_W-1:0];
  end

  assign clip_evt = in_vld & (over | under);

  // Output stage: one register, holds while no sample is offered.
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_out <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) smp_out <= sat_w;
    end
  end

  // Wide format: samples above the limit come out as the positive full scale.
  assert_one_sign_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fmt == FMT_ONE_SIGN && $signed(smp_in) > $signed(HI_ONE))
      |=> (smp_out == HI_ONE[OUT_W-1:0]));

  // Wide format: samples below the limit come out as the negative full scale.
  assert_one_sign_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fmt == FMT_ONE_SIGN && $signed(smp_in) < $signed(LO_ONE))
      |=> (smp_out == LO_ONE[OUT_W-1:0]));

  // Narrow format: both ends are folded to their full-scale codes.
  assert_two_sign_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fmt == FMT_TWO_SIGN && $signed(smp_in) > $signed(HI_TWO))
      |=> (smp_out == HI_TWO[OUT_W-1:0]));

  assert_two_sign_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fmt == FMT_TWO_SIGN && $signed(smp_in) < $signed(LO_TWO))
      |=> (smp_out == LO_TWO[OUT_W-1:0]));

  // In-range samples pass unchanged after one stage.
  assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fmt == FMT_ONE_SIGN &&
     $signed(smp_in) <= $signed(HI_ONE) && $signed(smp_in) >= $signed(LO_ONE))
      |=> (smp_out == $past(smp_in[OUT_W-1:0])));

  // The output holds while no sample is offered.
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(smp_out));

  // The valid flag follows the input valid by exactly one edge.
  assert_valid_lag_R4: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

endmodule

// File: rtl/rxsat_clip_flag.sv
module rxsat_clip_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic flag_o
);

  logic clr_req;

  // Only a written zero is a clear request; a written one is ignored.
  assign clr_req = clr_wr & ~clr_bit;

  // The set takes priority, so a clip in the clear cycle is not lost.
  always_ff @(posedge clk) begin
    if (rst)          flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clr_req) flag_o <= 1'b0;
  end

  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(clr_wr && !clr_bit)) |=> flag_o);

  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !clr_bit && !set_i) |=> !flag_o);

  assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_wr && !clr_bit) |=> flag_o);

  assert_rise_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(set_i));

endmodule

// File: rtl/rxsat_guard.sv
module rxsat_guard
  import rxsat_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  smp_in,
  input  logic             fmt_sel,
  input  logic             clr_wr,
  input  logic             clr_bit,
  output logic [OUT_W-1:0] smp_out,
  output logic             out_vld,
  output logic             clip_o,
  output logic             clip_sts
);

  rx_fmt_e fmt;
  logic    clip_evt;
  logic    flag;

  assign fmt = rx_fmt_e'(fmt_sel);

  rxsat_limiter #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) u_limiter (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .smp_in   (smp_in),
    .fmt      (fmt),
    .smp_out  (smp_out),
    .out_vld  (out_vld),
    .clip_evt (clip_evt)
  );

  rxsat_clip_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_i   (clip_evt),
    .clr_wr  (clr_wr),
    .clr_bit (clr_bit),
    .flag_o  (flag)
  );

  assign clip_o   = flag;
  assign clip_sts = flag;

  // Reset leaves every output in its idle state one edge later.
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (smp_out == '0 && !out_vld && !clip_o));

  // A written one never lowers the flag.
  assert_write_one_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (clip_o && clr_wr && clr_bit) |=> clip_o);

endmodule

// File: tb/rxsat_guard_bench.sv
module rxsat_guard_bench;

  localparam int IN_W  = 18;
  localparam int OUT_W = 16;
  localparam int NVEC  = 14;
  localparam int WDOG  = 20000;

  // Vector layout: {fmt_sel, sample, expected word, expected clip}.
  localparam logic [35:0] VECS [NVEC] = '{
    {1'b1, 18'h00123, 16'h0123, 1'b0},
    {1'b1, 18'h07FFF, 16'h7FFF, 1'b0},
    {1'b1, 18'h08000, 16'h7FFF, 1'b1},
    {1'b1, 18'h3FFFF, 16'hFFFF, 1'b0},
    {1'b1, 18'h38000, 16'h8000, 1'b0},
    {1'b1, 18'h37FFF, 16'h8000, 1'b1},
    {1'b1, 18'h1FFFF, 16'h7FFF, 1'b1},
    {1'b1, 18'h20000, 16'h8000, 1'b1},
    {1'b0, 18'h03FFF, 16'h3FFF, 1'b0},
    {1'b0, 18'h04000, 16'h3FFF, 1'b1},
    {1'b0, 18'h3C000, 16'hC000, 1'b0},
    {1'b0, 18'h3BFFF, 16'hC000, 1'b1},
    {1'b0, 18'h07FFF, 16'h3FFF, 1'b1},
    {1'b0, 18'h00000, 16'h0000, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in_vld;
  logic [IN_W-1:0]  smp_in;
  logic             fmt_sel;
  logic             clr_wr;
  logic             clr_bit;
  logic [OUT_W-1:0] smp_out;
  logic             out_vld;
  logic             clip_o;
  logic             clip_sts;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rxsat_guard #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rxsat_guard (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .smp_in   (smp_in),
    .fmt_sel  (fmt_sel),
    .clr_wr   (clr_wr),
    .clr_bit  (clr_bit),
    .smp_out  (smp_out),
    .out_vld  (out_vld),
    .clip_o   (clip_o),
    .clip_sts (clip_sts)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Let one rising edge pass; return at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic fmt, input logic [IN_W-1:0] s);
    fmt_sel = fmt;
    smp_in  = s;
    in_vld  = 1'b1;
    step();
    in_vld  = 1'b0;
  endtask

  task automatic write_clip(input logic b);
    clr_wr  = 1'b1;
    clr_bit = b;
    step();
    clr_wr  = 1'b0;
    clr_bit = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_vld = 1'b0; smp_in = '0; fmt_sel = 1'b1;
    clr_wr = 1'b0; clr_bit = 1'b0;
    @(negedge clk);
    step();
    step();
    // R1: idle outputs during reset
    check("R1 word",  32'(smp_out), 32'h0);
    check("R1 valid", 32'(out_vld), 32'h0);
    check("R1 clip",  32'(clip_o),  32'h0);
    check("R1 sts",   32'(clip_sts), 32'h0);
    rst = 1'b0;
    step();

    // Table walk: R2 / R3 for limited samples, R4 for passes, R5 for the flag.
    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] v;
      string tag;
      v = VECS[i];
      tag = v[0] ? (v[35] ? "R2" : "R3") : "R4";
      send(v[35], v[34:17]);
      check(tag, 32'(smp_out), 32'(v[16:1]));
      check("R4 valid", 32'(out_vld), 32'h1);
      check("R5 clip", 32'(clip_o), 32'(v[0]));
      check("R9 status", 32'(clip_sts), 32'(clip_o));
      write_clip(1'b0);
      check("R7 cleared", 32'(clip_o), 32'h0);
    end

    // R4: output holds while idle
    send(1'b1, 18'h01234);
    step();
    step();
    check("R4 hold", 32'(smp_out), 32'h1234);
    check("R4 valid low", 32'(out_vld), 32'h0);

    // R6: sticky across in-range traffic and idle time
    send(1'b1, 18'h0A000);
    check("R5 set", 32'(clip_o), 32'h1);
    for (int k = 0; k < 5; k++) send(1'b1, 18'(k * 100));
    for (int k = 0; k < 4; k++) step();
    check("R6 sticky", 32'(clip_o), 32'h1);
    check("R9 sticky status", 32'(clip_sts), 32'h1);

    // R7: writing a one leaves the flag alone
    write_clip(1'b1);
    check("R7 write one ignored", 32'(clip_o), 32'h1);
    write_clip(1'b0);
    check("R7 write zero", 32'(clip_o), 32'h0);
    check("R9 cleared status", 32'(clip_sts), 32'h0);

    // R8: clip and clear together keep the flag set
    fmt_sel = 1'b0; smp_in = 18'h3A000; in_vld = 1'b1;
    clr_wr = 1'b1; clr_bit = 1'b0;
    step();
    in_vld = 1'b0; clr_wr = 1'b0;
    check("R8 collision", 32'(clip_o), 32'h1);
    check("R3 collision word", 32'(smp_out), 32'h0000C000);
    write_clip(1'b0);
    check("R8 later clear", 32'(clip_o), 32'h0);

    // R1: reset in mid-run clears everything
    send(1'b1, 18'h10000);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 rerun word", 32'(smp_out), 32'h0);
    check("R1 rerun clip", 32'(clip_o), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule